// File: doc/BRIEF.md
# Variable-Block Carry-Select Adder

This block is a purely combinational two-operand adder with a carry input. The operand width is cut into slices that get wider toward the most significant end. The lowest slice is a plain ripple chain fed by the external carry. Every slice above it holds two ripple chains: one assumes an incoming carry of 0 and the other assumes 1. Once the true carry from the slice below is known, a two-way select picks one sum and one carry for each slice.

The slices grow wider so that the internal ripple of each slice finishes about when its select carry arrives. A parameter chooses either that growing layout or a single-stage split. In the single-stage split, the lower half is rippled directly and its carry picks one of two precomputed upper halves.

A small selection-control module turns the pairs of candidate carries into the chain of real carries. It hands that chain to the datapath as a struct of select strobes. The datapath holds the ripple slices and the sum multiplexers.

Top module: `varblock_csel_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of `opA + opB + carryIn` for every input pattern.
- R2: `carryOut` equals bit WIDTH of the (WIDTH+1)-bit value `opA + opB + carryIn`.
- R3: The lowest slice (bits 0 to FIRST_W-1) is a single ripple chain driven by `carryIn`, so `sumOut[3:0]` equals the low 4 bits of `opA[3:0] + opB[3:0] + carryIn` in the default layout.
- R4: In the default layout (ONE_STAGE=0, FIRST_W=4, WIDTH=32), the slices cover bits 0-3, 4-7, 8-12, 13-18, 19-25 and 26-31. From the third slice on, each slice is one bit wider than the one below it, and the last slice is cut short at bit 31. A carry that is generated just below any slice boundary (bit positions 4, 8, 13, 19, 26) arrives in the correct result.
- R5: With ONE_STAGE=1 the layout is two 16-bit halves, and the lower half's carry selects the upper half. That includes a carry that crosses bit 15 to bit 16.
- R6: A carry that enters at bit 0 propagates through every slice. All-ones plus 1 gives sum 0 and carry-out 1, and all-ones plus carry-in 1 does the same.
- R7: Alternating bit patterns (0xAAAAAAAA with 0x55555555, carry-in 0 and 1) give the arithmetic result. With carry-in 1 that result is sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | first addend |
| opB | input | WIDTH | second addend |
| carryIn | input | 1 | carry into bit 0 |
| sumOut | output | WIDTH | sum bits |
| carryOut | output | 1 | carry out of the top bit, taken from the selected top slice |

## Verification
Two functions can land on the same input vector: local generation inside a slice, and a long select-carry chain that must pass through every multiplexer. The bench provokes this with operands whose propagate bits span several slices while a generate sits just below a slice boundary, and with all-ones operands plus a carry. Each result is judged against a behavioural wide sum, in both the growing layout and the single-stage layout, and the sum bits and the carry-out are compared separately.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MAXBLK = 16;

  typedef struct packed {
    logic [MAXBLK:0] carry;   // real carry into each slice, last = carry-out
  } selStrobe_t;

  function automatic int rawWidth(int k, int firstW, bit oneStage, int width);
    if (oneStage) return width / 2;
    if (k == 0) return firstW;
    return firstW + k - 1;
  endfunction

  function automatic int blkStart(int k, int firstW, bit oneStage, int width);
    int s;
    int w;
    s = 0;
    for (int j = 0; j < k; j++) begin
      w = rawWidth(j, firstW, oneStage, width);
      if (s + w > width) w = width - s;
      s = s + w;
    end
    return s;
  endfunction

  function automatic int blkWidth(int k, int firstW, bit oneStage, int width);
    int s;
    int w;
    s = blkStart(k, firstW, oneStage, width);
    w = rawWidth(k, firstW, oneStage, width);
    if (s + w > width) w = width - s;
    return w;
  endfunction

  function automatic int numBlocks(int firstW, bit oneStage, int width);
    int n;
    n = 0;
    while (blkStart(n, firstW, oneStage, width) < width && n < MAXBLK) n++;
    return n;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
  assign co = c[W];
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int FIRST_W   = 4,
  parameter bit ONE_STAGE = 1'b0,
  localparam int NB       = numBlocks(FIRST_W, ONE_STAGE, WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  selStrobe_t       strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic [NB-1:0]    carryIfZero,
  output logic [NB-1:0]    carryIfOne
);
  for (genvar k = 0; k < NB; k++) begin : g_blk
    localparam int LO = blkStart(k, FIRST_W, ONE_STAGE, WIDTH);
    localparam int BW = blkWidth(k, FIRST_W, ONE_STAGE, WIDTH);
    if (k == 0) begin : g_low
      logic [BW-1:0] sLow;
      logic          cLow;
      csel_ripple #(.W(BW)) u_rip (
        .a(opA[LO +: BW]), .b(opB[LO +: BW]), .ci(strobes.carry[0]),
        .s(sLow), .co(cLow)
      );
      assign sumOut[LO +: BW] = sLow;
      assign carryIfZero[k]   = cLow;
      assign carryIfOne[k]    = cLow;
    end else begin : g_dual
      logic [BW-1:0] sZero, sOne;
      logic          cZero, cOne;
      csel_ripple #(.W(BW)) u_rip0 (
        .a(opA[LO +: BW]), .b(opB[LO +: BW]), .ci(1'b0),
        .s(sZero), .co(cZero)
      );
      csel_ripple #(.W(BW)) u_rip1 (
        .a(opA[LO +: BW]), .b(opB[LO +: BW]), .ci(1'b1),
        .s(sOne), .co(cOne)
      );
      assign sumOut[LO +: BW] = strobes.carry[k] ? sOne : sZero;
      assign carryIfZero[k]   = cZero;
      assign carryIfOne[k]    = cOne;
    end
  end
endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int NB = 6
) (
  input  logic          carryIn,
  input  logic [NB-1:0] carryIfZero,
  input  logic [NB-1:0] carryIfOne,
  output selStrobe_t    strobes,
  output logic          carryOut
);
  logic [NB:0] chain;

  always_comb begin
    chain[0] = carryIn;
    for (int k = 0; k < NB; k++) begin
      chain[k+1] = chain[k] ? carryIfOne[k] : carryIfZero[k];
    end
  end

  always_comb begin
    strobes = '0;
    strobes.carry[NB:0] = chain;
  end

  assign carryOut = chain[NB];
endmodule

// File: rtl/varblock_csel_adder.sv
module varblock_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int FIRST_W   = 4,
  parameter bit ONE_STAGE = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NB = numBlocks(FIRST_W, ONE_STAGE, WIDTH);

  selStrobe_t    strobes;
  logic [NB-1:0] carryIfZero;
  logic [NB-1:0] carryIfOne;

  csel_datapath #(.WIDTH(WIDTH), .FIRST_W(FIRST_W), .ONE_STAGE(ONE_STAGE)) u_dp (
    .opA(opA), .opB(opB), .strobes(strobes), .sumOut(sumOut),
    .carryIfZero(carryIfZero), .carryIfOne(carryIfOne)
  );

  csel_ctrl #(.NB(NB)) u_ctrl (
    .carryIn(carryIn), .carryIfZero(carryIfZero), .carryIfOne(carryIfOne),
    .strobes(strobes), .carryOut(carryOut)
  );
endmodule

// File: rtl/varblock_csel_adder_chk.sv
module varblock_csel_adder_chk #(
  parameter int WIDTH     = 32,
  parameter int FIRST_W   = 4,
  parameter bit ONE_STAGE = 1'b0
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0]   refSum;
  logic [FIRST_W:0] lowRef;

  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign lowRef = {1'b0, opA[FIRST_W-1:0]} + {1'b0, opB[FIRST_W-1:0]}
                + {{FIRST_W{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, sumOut, carryOut})) begin
      // R1
      sum_match_chk: assert (sumOut == refSum[WIDTH-1:0]);
      // R2
      carry_out_chk: assert (carryOut == refSum[WIDTH]);
      // R3
      low_slice_chk: assert (ONE_STAGE || sumOut[FIRST_W-1:0] == lowRef[FIRST_W-1:0]);
      // R6
      full_chain_chk: assert (!((opA ^ opB) == {WIDTH{1'b1}} && carryIn)
                              || (sumOut == '0 && carryOut));
    end
  end
endmodule

bind varblock_csel_adder varblock_csel_adder_chk #(
  .WIDTH(WIDTH), .FIRST_W(FIRST_W), .ONE_STAGE(ONE_STAGE)
) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
);

// File: tb/sim_varblock_csel_adder.sv
module sim_varblock_csel_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0;
  logic [31:0] sum0, sum1;
  logic        cout0, cout1;

  int checks = 0;
  int errors = 0;

  varblock_csel_adder u0 (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sum0), .carryOut(cout0)
  );
  varblock_csel_adder #(.ONE_STAGE(1'b1)) u1 (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sum1), .carryOut(cout1)
  );

  typedef struct {
    logic [31:0] sum;
    logic        cout;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input string tag);
    item_t it;
    logic [32:0] full;
    @(posedge clk);
    opA = a; opB = b; carryIn = ci;
    full = {1'b0, a} + {1'b0, b} + {32'd0, ci};
    it.sum = full[31:0];
    it.cout = full[32];
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic cmp(input logic [32:0] act, input logic [32:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        cmp({1'b0, sum0}, {1'b0, it.sum}, {it.tag, " R1 u0 sum"});
        cmp({32'd0, cout0}, {32'd0, it.cout}, {it.tag, " R2 u0 cout"});
        cmp({1'b0, sum1}, {1'b0, it.sum}, {it.tag, " R5 u1 sum"});
        cmp({32'd0, cout1}, {32'd0, it.cout}, {it.tag, " R5 u1 cout"});
        cmp({29'd0, sum0[3:0]}, {29'd0, it.sum[3:0]}, {it.tag, " R3 low slice"});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] ra, rb;
    int bounds [5] = '{4, 8, 13, 19, 26};
    // quiescent zero inputs
    drive(32'h0, 32'h0, 1'b0, "zero R1");
    drive(32'h0, 32'h0, 1'b1, "cin only R3");
    drive(32'h0000_000F, 32'h0, 1'b1, "low slice carry R3");
    // R6 full chain
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "ones plus one R6");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, "ones plus cin R6");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "ones plus ones R2");
    // R7 alternating
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "alternating cin0 R7");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "alternating cin1 R7");
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "alternating doubled R7");
    // R4 carry generated just below each slice boundary
    foreach (bounds[i]) begin
      drive((32'h1 << bounds[i]) - 32'h1, 32'h1, 1'b0, "boundary R4");
      drive((32'h1 << (bounds[i] - 1)), (32'h1 << (bounds[i] - 1)), 1'b0, "boundary gen R4");
      drive(32'hFFFF_FFFF << bounds[i], (32'h1 << bounds[i]) - 32'h1, 1'b1, "boundary long R4");
    end
    // R5 crossing of the half split
    drive(32'h0000_FFFF, 32'h1, 1'b0, "half split R5");
    drive(32'h7FFF_8000, 32'h0000_8000, 1'b0, "half split gen R5");
    // random
    for (int n = 0; n < 300; n++) begin
      ra = $urandom;
      rb = $urandom;
      drive(ra, rb, n[0], "random R1");
    end
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule